// File: doc/BRIEF.md
# Word Load/Store Sequencer over a Byte-Wide Memory Path

This block moves 16-bit register words to and from a 64K memory of one-byte cells, across an 8-bit data path that carries one byte per cycle. A request names one of three operations: a word load, a word store, or an immediate load that arrives as two bytes. A load or store takes its address either from a direct 16-bit field or from the contents of a pointer register. The block then runs two byte transfers and, for loads, returns the assembled word.

Words are kept big-endian. The more significant byte goes at the addressed cell and the less significant byte at the next cell. The second address is the first plus one, wrapping modulo 65536. The lowest 2048 bytes of the map are read-only. Any byte write aimed there is dropped, and the store reports it with an error pulse. Reads from that region behave as usual.

A request is accepted only while the block is idle. The block holds `busy` through the transfer and then pulses `done` for one cycle. The memory answers a read one cycle after the read strobe.

Top module: `word_mover`

## Requirements
- R1: After reset, `busy`, `done`, `romErr`, `memRe` and `memWe` are all low.
- R2: A load (reqKind code 0) reads the cell at the base address into bits 15:8 of `rdWord` and the cell at base+1 into bits 7:0. `rdWord` is valid while `done` is high.
- R3: A store (reqKind code 1) writes bits 15:8 of `reqWData` to the base address and bits 7:0 to base+1, one byte per cycle, in that order. The memory strobes are only active while `busy` is high.
- R4: With `reqUsePtr` = 1 the base address is `reqPtr`. With `reqUsePtr` = 0 it is `reqDirect`. The unselected field has no effect.
- R5: The second byte address is the base plus one, modulo 65536, so base 0xFFFF pairs with 0x0000.
- R6: An immediate load (reqKind code 2) takes `immByte` as bits 15:8 on the first cycle with `immValid` high after acceptance, and as bits 7:0 on the next such cycle. It waits through any cycles with `immValid` low.
- R7: `memWe` is never high with `memAddr` below 2048. A blocked byte leaves the memory cell unchanged. The other byte of the same store is still written if it lies at 2048 or above.
- R8: `romErr` is high for exactly the cycle in which `done` is high, if at least one byte of that store was blocked. It stays low for every other operation.
- R9: `busy` rises on the edge that accepts a request and stays high until `done` rises. `done` is a one-cycle pulse. For loads and stores, `done` is high after the fourth rising edge, counting the accepting edge as the first. For an immediate load with g idle cycles, `done` comes g cycles later than that.
- R10: A request presented while `busy` is high is ignored, and so is a request with reqKind code 3. Neither starts a transfer nor touches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | 0 load, 1 store, 2 immediate load, 3 reserved |
| reqUsePtr | input | 1 | Select pointer register as the address source |
| reqDirect | input | 16 | Direct address |
| reqPtr | input | 16 | Pointer register contents |
| reqWData | input | 16 | Register word to store |
| immValid | input | 1 | Immediate byte present |
| immByte | input | 8 | Immediate byte, high byte first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdWord | output | 16 | Assembled word for loads |
| romErr | output | 1 | A store byte hit the read-only region |
| memAddr | output | 16 | Byte address to memory |
| memRe | output | 1 | Read strobe; data returns next cycle |
| memWe | output | 1 | Write strobe |
| memWData | output | 8 | Write byte |
| memRData | input | 8 | Read byte |

## Verification
Several properties are checked on every cycle. No write strobe reaches the read-only region. The second strobe of a pair always lands on the first address plus one, wrapping included. Memory strobes occur only while busy. `done` is a single-cycle pulse that never overlaps `busy`, and `romErr` never appears without `done`. Other behaviour can only be shown by the bench's scenarios. That covers big-endian byte order in both directions, the choice between pointer and direct address, the pacing of immediate bytes, the exact completion latency, and the rejection of requests while busy or with the reserved code. The bench shows these by reading memory contents and returned words after chosen sequences of operations.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_IMM   = 2'd2
  } kind_e;

  // Strobes from control to datapath. Lane index 1 = high byte, 0 = low byte.
  typedef struct packed {
    logic       latchReq;
    logic       addrNext;
    logic       byteSel;
    logic       memRe;
    logic       memWe;
    logic [1:0] capMem;
    logic [1:0] capImm;
  } strobe_t;
endpackage

// File: rtl/wm_datapath.sv
module wm_datapath #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int ROM_BYTES = 2048
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wm_pkg::strobe_t       stb,
  input  logic                  doneIn,
  input  logic                  reqUsePtr,
  input  logic [ADDR_W-1:0]     reqDirect,
  input  logic [ADDR_W-1:0]     reqPtr,
  input  logic [WORD_W-1:0]     reqWData,
  input  logic [WORD_W/2-1:0]   immByte,
  input  logic [WORD_W/2-1:0]   memRData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRe,
  output logic                  memWe,
  output logic [WORD_W/2-1:0]   memWData,
  output logic [WORD_W-1:0]     rdWord,
  output logic                  romErr
);
  localparam int BYTE_W = WORD_W / 2;
  localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(ROM_BYTES);

  logic [ADDR_W-1:0]            baseAddr;
  logic [WORD_W-1:0]            wdataReg;
  logic                         blockedSeen;
  logic                         inRom;
  logic [1:0][BYTE_W-1:0]       laneReg;

  // Second byte address wraps naturally at the address width.
  assign memAddr  = stb.addrNext ? baseAddr + ADDR_W'(1) : baseAddr;
  assign inRom    = memAddr < ROM_LIMIT;
  assign memRe    = stb.memRe;
  assign memWe    = stb.memWe && !inRom;
  assign memWData = stb.byteSel ? wdataReg[BYTE_W-1:0] : wdataReg[WORD_W-1:BYTE_W];
  assign romErr   = doneIn && blockedSeen;
  assign rdWord   = laneReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr    <= '0;
      wdataReg    <= '0;
      blockedSeen <= 1'b0;
    end else if (stb.latchReq) begin
      baseAddr    <= reqUsePtr ? reqPtr : reqDirect;
      wdataReg    <= reqWData;
      blockedSeen <= 1'b0;
    end else if (stb.memWe && inRom) begin
      blockedSeen <= 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              laneReg[g] <= '0;
      else if (stb.capMem[g]) laneReg[g] <= memRData;
      else if (stb.capImm[g]) laneReg[g] <= immByte;
    end
  end
endmodule

// File: rtl/wm_control.sv
module wm_control (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic            immValid,
  output wm_pkg::strobe_t stb,
  output logic            busy,
  output logic            done
);
  import wm_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_BYTE0, ST_BYTE1, ST_TAIL} state_e;

  state_e state, stateNext;
  kind_e  kindReg;
  logic   accept;

  assign accept = (state == ST_IDLE) && reqValid && (reqKind != 2'd3);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.latchReq = 1'b1;
          stateNext    = ST_BYTE0;
        end
      end
      ST_BYTE0: begin
        case (kindReg)
          KIND_LOAD:  begin stb.memRe = 1'b1; stateNext = ST_BYTE1; end
          KIND_STORE: begin stb.memWe = 1'b1; stateNext = ST_BYTE1; end
          default: begin
            if (immValid) begin
              stb.capImm[1] = 1'b1;
              stateNext     = ST_BYTE1;
            end
          end
        endcase
      end
      ST_BYTE1: begin
        case (kindReg)
          KIND_LOAD: begin
            stb.memRe     = 1'b1;
            stb.addrNext  = 1'b1;
            stb.capMem[1] = 1'b1;
            stateNext     = ST_TAIL;
          end
          KIND_STORE: begin
            stb.memWe    = 1'b1;
            stb.addrNext = 1'b1;
            stb.byteSel  = 1'b1;
            stateNext    = ST_TAIL;
          end
          default: begin
            if (immValid) begin
              stb.capImm[0] = 1'b1;
              stateNext     = ST_TAIL;
            end
          end
        endcase
      end
      default: begin
        stb.capMem[0] = (kindReg == KIND_LOAD);
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= KIND_LOAD;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_TAIL);
      if (accept) kindReg <= kind_e'(reqKind);
    end
  end
endmodule

// File: rtl/word_mover.sv
module word_mover #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int ROM_BYTES = 2048
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic                reqUsePtr,
  input  logic [ADDR_W-1:0]   reqDirect,
  input  logic [ADDR_W-1:0]   reqPtr,
  input  logic [WORD_W-1:0]   reqWData,
  input  logic                immValid,
  input  logic [WORD_W/2-1:0] immByte,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   rdWord,
  output logic                romErr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRe,
  output logic                memWe,
  output logic [WORD_W/2-1:0] memWData,
  input  logic [WORD_W/2-1:0] memRData
);
  wm_pkg::strobe_t stb;

  wm_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .immValid(immValid), .stb(stb), .busy(busy), .done(done)
  );

  wm_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROM_BYTES(ROM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .doneIn(done),
    .reqUsePtr(reqUsePtr), .reqDirect(reqDirect), .reqPtr(reqPtr),
    .reqWData(reqWData), .immByte(immByte), .memRData(memRData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWData(memWData),
    .rdWord(rdWord), .romErr(romErr)
  );
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 2048
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              romErr,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(ROM_BYTES);

  assert_no_rom_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr >= ROM_LIMIT);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    romErr |-> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_from_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  assert_strobe_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busy);

  assert_read_pair_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> memAddr == $past(memAddr) + ADDR_W'(1));
endmodule

bind word_mover wm_checker #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .romErr(romErr), .memRe(memRe), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/word_mover_tb_top.sv
module word_mover_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic        reqUsePtr = 1'b0;
  logic [15:0] reqDirect = '0, reqPtr = '0, reqWData = '0;
  logic        immValid = 1'b0;
  logic [7:0]  immByte = '0;
  logic        busy, done, romErr, memRe, memWe;
  logic [15:0] rdWord, memAddr;
  logic [7:0]  memWData;
  logic [7:0]  memRData = '0;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  word_mover dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqUsePtr(reqUsePtr), .reqDirect(reqDirect), .reqPtr(reqPtr),
    .reqWData(reqWData), .immValid(immValid), .immByte(immByte),
    .busy(busy), .done(done), .rdWord(rdWord), .romErr(romErr),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWData(memWData), .memRData(memRData)
  );

  // Memory model: unwritten cells hold a pattern derived from the address.
  logic [7:0] memCells [int];

  function automatic logic [7:0] fillByte(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] peek(input logic [15:0] a);
    if (memCells.exists(int'(a))) return memCells[int'(a)];
    return fillByte(a);
  endfunction

  always @(posedge clk) begin
    if (memWe) memCells[int'(memAddr)] = memWData;
    memRData <= memRe ? peek(memAddr) : 8'h00;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic runOp(input logic [1:0] k, input logic up, input logic [15:0] dA,
                       input logic [15:0] pA, input logic [15:0] wd, input int gap,
                       output logic [15:0] word, output logic err, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqUsePtr = up;
    reqDirect = dA; reqPtr = pA; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    check("R9 busy after accept", 32'(busy), 32'd1);
    if (k == 2'd2) begin
      repeat (gap) begin @(negedge clk); lat++; end
      immValid = 1'b1; immByte = wd[15:8];
      @(negedge clk); lat++;
      immByte = wd[7:0];
      @(negedge clk); lat++;
      immValid = 1'b0;
    end
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    word = rdWord;
    err  = romErr;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic        usePtr;
    logic [15:0] direct;
    logic [15:0] ptr;
    logic [15:0] wdata;
    logic [3:0]  gap;
    logic [15:0] expWord;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b0, 16'h1234, 16'h0000, 16'hBEEF, 4'd0, 16'h0000, 1'b0},
    '{2'd0, 1'b0, 16'h1234, 16'h0000, 16'h0000, 4'd0, 16'hBEEF, 1'b0},
    '{2'd1, 1'b1, 16'h9999, 16'h4000, 16'hA55A, 4'd0, 16'h0000, 1'b0},
    '{2'd0, 1'b1, 16'h1234, 16'h4000, 16'h0000, 4'd0, 16'hA55A, 1'b0},
    '{2'd2, 1'b0, 16'h0000, 16'h0000, 16'h7E81, 4'd0, 16'h7E81, 1'b0},
    '{2'd2, 1'b0, 16'h0000, 16'h0000, 16'h0102, 4'd2, 16'h0102, 1'b0},
    '{2'd1, 1'b0, 16'hFFFF, 16'h0000, 16'hC3D2, 4'd0, 16'h0000, 1'b1},
    '{2'd0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'd0, 16'hC35A, 1'b0},
    '{2'd1, 1'b0, 16'h07FF, 16'h0000, 16'h1122, 4'd0, 16'h0000, 1'b1},
    '{2'd0, 1'b0, 16'h07FF, 16'h0000, 16'h0000, 4'd0, 16'hA222, 1'b0},
    '{2'd1, 1'b0, 16'h0100, 16'h0000, 16'hDEAD, 4'd0, 16'h0000, 1'b1},
    '{2'd0, 1'b0, 16'h0100, 16'h0000, 16'h0000, 4'd0, 16'h5B5A, 1'b0},
    '{2'd1, 1'b0, 16'h0800, 16'h0000, 16'h3344, 4'd0, 16'h0000, 1'b0},
    '{2'd0, 1'b0, 16'h0800, 16'h0000, 16'h0000, 4'd0, 16'h3344, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] word;
    logic        err;
    int          lat;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 romErr", 32'(romErr), 32'd0);
    check("R1 strobes", 32'({memRe, memWe}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i].kind, VECS[i].usePtr, VECS[i].direct, VECS[i].ptr,
            VECS[i].wdata, int'(VECS[i].gap), word, err, lat);
      if (VECS[i].kind == 2'd0) check($sformatf("R2 load word vec %0d", i), 32'(word), 32'(VECS[i].expWord));
      if (VECS[i].kind == 2'd2) check($sformatf("R6 immediate word vec %0d", i), 32'(word), 32'(VECS[i].expWord));
      check($sformatf("R8 romErr vec %0d", i), 32'(err), 32'(VECS[i].expErr));
      check($sformatf("R9 latency vec %0d", i), 32'(lat), 32'(4 + int'(VECS[i].gap)));
      @(negedge clk);
      check($sformatf("R9 done one cycle vec %0d", i), 32'({done, romErr, busy}), 32'd0);
    end

    // R3: big-endian placement in memory
    check("R3 high byte at base", 32'(peek(16'h1234)), 32'hBE);
    check("R3 low byte at base+1", 32'(peek(16'h1235)), 32'hEF);
    // R4: pointer used, direct field ignored
    check("R4 pointer target", 32'(peek(16'h4000)), 32'hA5);
    check("R4 direct untouched", 32'(peek(16'h9999)), 32'(fillByte(16'h9999)));
    // R5: wrap from 0xFFFF to 0x0000
    check("R5 wrap high byte", 32'(peek(16'hFFFF)), 32'hC3);
    // R7: blocked bytes unchanged, neighbour above the region written
    check("R7 cell 0 protected", 32'(peek(16'h0000)), 32'(fillByte(16'h0000)));
    check("R7 cell 07FF protected", 32'(peek(16'h07FF)), 32'(fillByte(16'h07FF)));
    check("R7 cell 0800 written", 32'(peek(16'h0800)), 32'h33);
    check("R7 cell 0100 protected", 32'(peek(16'h0100)), 32'(fillByte(16'h0100)));

    // R10: request held while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqUsePtr = 1'b0; reqDirect = 16'h1234;
    @(negedge clk);
    reqKind = 2'd1; reqDirect = 16'h3000; reqWData = 16'h7777;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    reqValid = 1'b0;
    check("R10 load during held request", 32'(rdWord), 32'hBEEF);
    @(negedge clk);
    check("R10 no re-accept", 32'(busy), 32'd0);
    check("R10 busy request dropped", 32'(peek(16'h3000)), 32'(fillByte(16'h3000)));

    // R10: reserved code 3 not accepted
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd3; reqDirect = 16'h3000;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 reserved code busy", 32'(busy), 32'd0);
    check("R10 reserved code strobes", 32'({memRe, memWe}), 32'd0);
    repeat (4) @(negedge clk);
    check("R10 reserved code no done", 32'(done), 32'd0);
    check("R10 reserved code memory", 32'(peek(16'h3000)), 32'(fillByte(16'h3000)));

    summary();
    $finish;
  end
endmodule